// File: doc/BRIEF.md
# Fixed-Latency Iterative Divide/Square-Root Wrapper

This block sits around a non-pipelined iterative arithmetic engine whose run time depends on the operand values. Divides finish in 15 or 18 cycles and square roots in 23 or 26. By default the wrapper releases each result as soon as the engine reports completion. When the analysis-mode bit is set at the start of an operation, the engine's early completion is hidden. The result is then released only after the worst-case count for that operation type, so every measured latency is independent of the operands.

The engine is a stub. It computes a simple, checkable function of the operand, and its completion time is chosen per request through a short-path select input. That input stands in for operand-dependent early termination.

Requests enter on a valid/ready handshake. `in_ready` is low while an operation is in flight, so a requester holding `in_valid` high simply waits; nothing is dropped. Results leave as a single-cycle `out_valid` pulse with no back-pressure: the consumer must take `out_data` in that cycle. `out_data` is still held until the next completion.

Top module: `worst_lat_unit`

## Requirements
- R1: Only one operation is in flight at a time. `in_ready` equals `!busy`. A request presented while busy is not accepted and waits until `in_ready` returns high.
- R2: `in_op` = 0 selects divide and `in_op` = 1 selects square root. The stub engine completes after 15 (divide) or 23 (square root) cycles when `in_short` = 1, and after 18 or 26 cycles when `in_short` = 0. Latency is the number of rising edges from the accepting edge up to and including the edge after which `out_valid` is high.
- R3: With analysis mode off at acceptance, `out_valid` is released in the cycle the engine completes, so latency follows the engine: 15, 18, 23 or 26.
- R4: With analysis mode on at acceptance, every divide takes exactly 18 cycles and every square root exactly 26 cycles, for any `in_short` and operand.
- R5: A divide returns the bitwise inverse of the operand. A square root returns the operand with its upper and lower halves swapped. The value is identical in both modes.
- R6: `out_data` holds its value from one completion until the next.
- R7: `out_valid` is high for exactly one cycle per accepted operation.
- R8: `analysis_mode`, `in_a`, `in_short` and `in_op` are sampled only at acceptance. Changing them during an operation has no effect on that operation's latency or result.
- R9: After reset, `busy` = 0, `in_ready` = 1, `out_valid` = 0 and `out_data` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Unit can accept a request |
| in_op | input | 1 | 0 divide, 1 square root |
| in_short | input | 1 | Stub engine takes its short (early) path |
| in_a | input | DATA_W | Operand |
| analysis_mode | input | 1 | Pad to worst-case latency (sampled at acceptance) |
| out_valid | output | 1 | Single-cycle result strobe |
| out_data | output | DATA_W | Result, held until next completion |
| busy | output | 1 | Operation in flight |

## Verification
A wrong padding counter or a mis-sampled mode bit shows up directly as a latency that differs from 15, 18, 23 or 26 edges; it is visible at the first `out_valid` after the fault. A result register that captures at the wrong time shows as a wrong or drifting `out_data`, either in the strobe cycle or a few cycles later. A stuck in-flight flag shows as `in_ready` staying low, or as `out_valid` lasting more than one cycle, right after completion. Operand and mode changes made in mid-flight expose any sampling outside the acceptance edge within the same operation.

// File: rtl/wlu_pkg.sv
package wlu_pkg;
  typedef enum logic {
    OP_DIV  = 1'b0,
    OP_SQRT = 1'b1
  } op_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/iter_stub_core.sv
module iter_stub_core
  import wlu_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int DIV_FAST  = 15,
  parameter int DIV_SLOW  = 18,
  parameter int SQRT_FAST = 23,
  parameter int SQRT_SLOW = 26,
  parameter int CW        = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  op_e               op_i,
  input  logic              short_i,
  input  logic [DATA_W-1:0] a_i,
  output logic              done_o,
  output logic [DATA_W-1:0] result_o
);
  localparam int HALF = DATA_W / 2;
  localparam logic [CW-1:0] LAT_M1 [2][2] = '{
    '{CW'(DIV_SLOW - 1),  CW'(DIV_FAST - 1)},
    '{CW'(SQRT_SLOW - 1), CW'(SQRT_FAST - 1)}
  };

  logic              run_q;
  logic [CW-1:0]     cnt_q;
  op_e               op_q;
  logic [DATA_W-1:0] a_q;

  assign done_o = run_q && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      op_q  <= OP_DIV;
      a_q   <= '0;
    end else if (start_i) begin
      run_q <= 1'b1;
      cnt_q <= LAT_M1[op_i][short_i];
      op_q  <= op_i;
      a_q   <= a_i;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  // Stub arithmetic: divide -> inverse, square root -> half swap.
  generate
    if ((DATA_W % 2) == 0) begin : g_even
      always_comb begin
        if (op_q == OP_SQRT) result_o = {a_q[HALF-1:0], a_q[DATA_W-1:HALF]};
        else                 result_o = ~a_q;
      end
    end else begin : g_odd
      always_comb begin
        if (op_q == OP_SQRT) result_o = {a_q[HALF:0], a_q[DATA_W-1:HALF+1]};
        else                 result_o = ~a_q;
      end
    end
  endgenerate

  // R1: the engine is never restarted while an iteration is in progress
  assert_core_idle_at_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !run_q);
endmodule

// File: rtl/lat_pad_ctrl.sv
module lat_pad_ctrl
  import wlu_pkg::*;
#(
  parameter int DIV_SLOW  = 18,
  parameter int SQRT_SLOW = 26,
  parameter int CW        = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  op_e  op_i,
  input  logic mode_i,
  input  logic core_done_i,
  output logic busy_o,
  output logic release_o
);
  localparam logic [CW-1:0] WORST_M1 [2] = '{CW'(DIV_SLOW - 1), CW'(SQRT_SLOW - 1)};

  logic          active_q;
  logic          mode_q;
  logic          got_q;
  logic [CW-1:0] cnt_q;
  logic          rel_now;
  logic          out_q;

  always_comb begin
    if (!active_q)   rel_now = 1'b0;
    else if (mode_q) rel_now = (cnt_q == '0) && (got_q || core_done_i);
    else             rel_now = core_done_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      mode_q   <= 1'b0;
      got_q    <= 1'b0;
      cnt_q    <= '0;
      out_q    <= 1'b0;
    end else begin
      out_q <= rel_now;
      if (start_i) begin
        active_q <= 1'b1;
        mode_q   <= mode_i;
        got_q    <= 1'b0;
        cnt_q    <= WORST_M1[op_i];
      end else if (active_q) begin
        if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
        if (core_done_i) got_q <= 1'b1;
        if (rel_now)     active_q <= 1'b0;
      end
    end
  end

  assign busy_o    = active_q;
  assign release_o = out_q;

  // R3: in operation mode the engine's completion is forwarded on the next edge
  assert_early_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !mode_q && core_done_i) |=> release_o);

  // R7: single-cycle result strobe
  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    release_o |=> !release_o);
endmodule

// File: rtl/result_hold.sv
module result_hold #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_o <= '0;
    else if (cap_i) q_o <= d_i;
  end
endmodule

// File: rtl/worst_lat_unit.sv
module worst_lat_unit
  import wlu_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int DIV_FAST  = 15,
  parameter int DIV_SLOW  = 18,
  parameter int SQRT_FAST = 23,
  parameter int SQRT_SLOW = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_op,
  input  logic              in_short,
  input  logic [DATA_W-1:0] in_a,
  input  logic              analysis_mode,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              busy
);
  localparam int MAX_LAT = max2(max2(DIV_FAST, DIV_SLOW), max2(SQRT_FAST, SQRT_SLOW));
  localparam int CW      = $clog2(MAX_LAT + 2);

  logic              start;
  logic              core_done;
  logic [DATA_W-1:0] core_res;
  op_e               op_in;

  assign op_in    = op_e'(in_op);
  assign in_ready = !busy;
  assign start    = in_valid && in_ready;

  iter_stub_core #(
    .DATA_W(DATA_W), .DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW),
    .SQRT_FAST(SQRT_FAST), .SQRT_SLOW(SQRT_SLOW), .CW(CW)
  ) u_core (
    .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(op_in),
    .short_i(in_short), .a_i(in_a), .done_o(core_done), .result_o(core_res)
  );

  lat_pad_ctrl #(
    .DIV_SLOW(DIV_SLOW), .SQRT_SLOW(SQRT_SLOW), .CW(CW)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(op_in),
    .mode_i(analysis_mode), .core_done_i(core_done),
    .busy_o(busy), .release_o(out_valid)
  );

  result_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .cap_i(core_done), .d_i(core_res), .q_o(out_data)
  );

  // Elapsed-cycle observer for latency properties.
  logic [CW-1:0] chk_elapsed;
  logic          chk_mode;
  op_e           chk_op;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_elapsed <= '0;
      chk_mode    <= 1'b0;
      chk_op      <= OP_DIV;
    end else if (start) begin
      chk_elapsed <= '0;
      chk_mode    <= analysis_mode;
      chk_op      <= op_in;
    end else if (busy && chk_elapsed != '1) begin
      chk_elapsed <= chk_elapsed + 1'b1;
    end
  end

  // R1: an accepted request makes the unit busy on the next cycle
  assert_busy_after_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

  // R4: analysis-mode operations always take the worst-case count
  assert_fixed_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && chk_mode) |->
      (chk_elapsed == ((chk_op == OP_SQRT) ? CW'(SQRT_SLOW) : CW'(DIV_SLOW))));

  // R6: result register only moves when the engine completes
  assert_result_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !core_done |=> $stable(out_data));
endmodule

// File: tb/sim_worst_lat_unit.sv
`timescale 1ns/1ps
module sim_worst_lat_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_op = 1'b0;
  logic        in_short = 1'b0;
  logic [63:0] in_a = '0;
  logic        analysis_mode = 1'b0;
  logic        out_valid;
  logic [63:0] out_data;
  logic        busy;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  worst_lat_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_short(in_short), .in_a(in_a),
    .analysis_mode(analysis_mode), .out_valid(out_valid),
    .out_data(out_data), .busy(busy)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      total++; bad++;
      $display("FAIL watchdog: run hung act=%0d exp<=50000 cycles", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint unsigned act, input longint unsigned exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_res(input logic op, input logic [63:0] a);
    return op ? {a[31:0], a[63:32]} : ~a;
  endfunction

  function automatic int exp_lat(input logic op, input logic sh, input logic mode);
    if (mode) return op ? 26 : 18;
    return op ? (sh ? 23 : 26) : (sh ? 15 : 18);
  endfunction

  // Issue one operation; optionally scramble inputs mid-flight.
  task automatic run_op(input logic op, input logic [63:0] a, input logic sh,
                        input logic mode, input bit perturb,
                        output int lat, output logic [63:0] data, output bit pulse_ok);
    @(negedge clk);
    in_op = op; in_a = a; in_short = sh; analysis_mode = mode; in_valid = 1'b1;
    @(posedge clk);
    lat = 0;
    forever begin
      @(negedge clk);
      if (lat == 0) in_valid = 1'b0;
      if (perturb && lat == 3) begin
        analysis_mode = ~mode; in_a = ~a; in_short = ~sh; in_op = ~op;
      end
      if (out_valid || lat > 60) break;
      @(posedge clk);
      lat++;
    end
    data = out_data;
    @(negedge clk);
    pulse_ok = !out_valid;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(busy == 1'b0, "R9", "busy after reset", busy, 0);
    check(in_ready == 1'b1, "R9", "in_ready after reset", in_ready, 1);
    check(out_valid == 1'b0, "R9", "out_valid after reset", out_valid, 0);
    check(out_data == 64'h0, "R9", "out_data after reset", out_data, 0);
  endtask

  task automatic t_op(input logic op, input logic [63:0] a, input logic sh,
                      input logic mode, input string req);
    int lat; logic [63:0] d; bit p;
    run_op(op, a, sh, mode, 1'b0, lat, d, p);
    check(lat == exp_lat(op, sh, mode), req, "latency", lat, exp_lat(op, sh, mode));
    check(d == exp_res(op, a), "R5", "result", d, exp_res(op, a));
    check(p, "R7", "strobe width", !p, 0);
  endtask

  // R4: same type, different operands and paths, identical latency
  task automatic t_analysis_equal(input logic op);
    int l1, l2; logic [63:0] d1, d2; bit p1, p2;
    run_op(op, 64'h0123_4567_89AB_CDEF, 1'b1, 1'b1, 1'b0, l1, d1, p1);
    run_op(op, 64'hFFFF_0000_1234_0001, 1'b0, 1'b1, 1'b0, l2, d2, p2);
    check(l1 == l2, "R4", "analysis latencies equal", l1, l2);
    check(d1 == exp_res(op, 64'h0123_4567_89AB_CDEF), "R5", "analysis result",
          d1, exp_res(op, 64'h0123_4567_89AB_CDEF));
  endtask

  // R8: mid-flight changes to mode, operand, path and op are ignored
  task automatic t_perturb(input logic op, input logic sh, input logic mode);
    int lat; logic [63:0] d; bit p;
    logic [63:0] a = 64'hA5A5_0F0F_3C3C_9696;
    run_op(op, a, sh, mode, 1'b1, lat, d, p);
    check(lat == exp_lat(op, sh, mode), "R8", "latency after mid-op change",
          lat, exp_lat(op, sh, mode));
    check(d == exp_res(op, a), "R8", "result after mid-op change", d, exp_res(op, a));
    check(p, "R7", "strobe width", !p, 0);
  endtask

  // R6: out_data holds after the strobe
  task automatic t_hold();
    int lat; logic [63:0] d; bit p;
    run_op(1'b1, 64'hDEAD_BEEF_CAFE_F00D, 1'b1, 1'b0, 1'b0, lat, d, p);
    repeat (6) @(negedge clk);
    check(out_data == d, "R6", "held result", out_data, d);
    check(busy == 1'b0, "R1", "idle after completion", busy, 0);
  endtask

  // R1: second request waits while busy, then runs with its own latency
  task automatic t_backpressure();
    int lat; bit blocked_ok;
    logic [63:0] a1 = 64'h1111_2222_3333_4444;
    logic [63:0] a2 = 64'h5555_6666_7777_8888;
    @(negedge clk);
    in_op = 1'b0; in_a = a1; in_short = 1'b1; analysis_mode = 1'b0; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_op = 1'b1; in_a = a2; in_short = 1'b0;
    blocked_ok = 1'b1;
    lat = 0;
    while (!out_valid && lat < 60) begin
      if (in_ready || !busy) blocked_ok = 1'b0;
      @(negedge clk);
      lat++;
    end
    check(blocked_ok, "R1", "in_ready low while busy", !blocked_ok, 0);
    check(out_data == exp_res(1'b0, a1), "R1", "first result intact",
          out_data, exp_res(1'b0, a1));
    check(in_ready == 1'b1, "R1", "ready in strobe cycle", in_ready, 1);
    @(posedge clk);
    lat = 0;
    forever begin
      @(negedge clk);
      if (lat == 0) in_valid = 1'b0;
      if (out_valid || lat > 60) break;
      @(posedge clk);
      lat++;
    end
    check(lat == 26, "R2", "queued sqrt latency", lat, 26);
    check(out_data == exp_res(1'b1, a2), "R5", "queued sqrt result",
          out_data, exp_res(1'b1, a2));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_op(1'b0, 64'h0000_0000_0000_0001, 1'b1, 1'b0, "R3");
    t_op(1'b0, 64'h8000_0000_0000_0000, 1'b0, 1'b0, "R3");
    t_op(1'b1, 64'h1234_5678_9ABC_DEF0, 1'b1, 1'b0, "R2");
    t_op(1'b1, 64'hFEDC_BA98_7654_3210, 1'b0, 1'b0, "R2");
    t_op(1'b0, 64'h0F0F_0F0F_0F0F_0F0F, 1'b1, 1'b1, "R4");
    t_op(1'b1, 64'h0000_FFFF_0000_FFFF, 1'b1, 1'b1, "R4");
    t_analysis_equal(1'b0);
    t_analysis_equal(1'b1);
    t_perturb(1'b0, 1'b1, 1'b1);
    t_perturb(1'b0, 1'b1, 1'b0);
    t_perturb(1'b1, 1'b0, 1'b0);
    t_hold();
    t_backpressure();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule